// File: doc/BRIEF.md
# Bit-Serial Cartridge Scratch RAM Port Pair

This block gives a processor with an 8-bit I/O space access to a 1024 x 1-bit static RAM through two byte-wide ports. The processor writes a control byte and an address byte into two latches. The ten bits of the cell address are spread across those two latches in a fixed, non-contiguous pattern. The control byte also holds a read/write select bit and the data-in bit. The storage write happens during the control-port write itself, so a program first sets the address port and then issues one control write per bit stored.

Reading the control port in read mode returns the control latch with its top bit replaced by the RAM cell at the current address. The port pair answers in two alternate I/O windows. Both latches and every cell clear on reset. The read path is combinational from registered state, so a read issued in the same cycle as a write sees the contents from before that write.

Top module: `bitserial_cart_ram`

## Requirements
- R1: A write to the control port stores the whole byte in the control latch. Its fields are: bit 0 is the select (1 = write mode, 0 = read mode), bit 1 is cell address bit 3, bit 2 is cell address bit 2, and bit 3 is the data-in bit.
- R2: A write to the address port stores the whole byte in the address latch. Its bits 0,1,2,3,4,5,6,7 supply cell address bits 0,4,5,6,1,7,8,9.
- R3: A control-port write with select 1 stores data-in into the cell addressed by the newly written control bits together with the current address latch. The stored bit can be read back from the next cycle on.
- R4: A control-port read while the control latch select is 0 returns the control latch with bit 7 replaced by the cell at the current address.
- R5: A control-port read while the control latch select is 1 returns the control latch unchanged.
- R6: An address-port read returns the address latch. Address-port writes never change any RAM cell.
- R7: I/O addresses 0x20 and 0x24 select the control port, and 0x21 and 0x25 select the address port. Accesses to any other address change nothing, and `ioRdData` is 0x00 whenever no port is being read.
- R8: After reset both latches read as 0x00 and every cell holds 0.
- R9: A read in the same cycle as a write returns the latch and cell values from before the write.
- R10: A control-port write with select 0 leaves every RAM cell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 8 | I/O port address of the current access |
| ioWrEn | input | 1 | Write strobe for ioAddr |
| ioRdEn | input | 1 | Read strobe for ioAddr |
| ioWrData | input | 8 | Byte written |
| ioRdData | output | 8 | Byte read (combinational, 0x00 when not read) |

## Verification
The bench targets the scattered address mapping by walking a one through every cell address bit, writing and reading back. A swapped or misplaced bit would then alias two cells and return a stale value. It checks that the commit uses the control bits being written rather than the old ones; a design that used the stale address bits 2 and 3 would store into the wrong cell. It mixes reads and writes in the same cycle to catch a read path that shows post-write data, and it checks both windows, unmapped addresses, and select-0 and address-port writes that must leave the RAM untouched.

// File: rtl/cram_pkg.sv
package cram_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 10;
  localparam int DEPTH   = 1 << ADDR_W;

  // control-byte field positions (decoded by the datapath)
  localparam int SEL_BIT  = 0;
  localparam int A3_BIT   = 1;
  localparam int A2_BIT   = 2;
  localparam int DIN_BIT  = 3;
  localparam int DOUT_BIT = 7;

  typedef struct packed {
    logic ctlWr;
    logic adrWr;
    logic ctlRd;
    logic adrRd;
  } cramStrobes_t;

  // cell address bit fed by address-latch bit i
  function automatic int adrBitPos(input int i);
    case (i)
      0: return 0;
      1: return 4;
      2: return 5;
      3: return 6;
      4: return 1;
      5: return 7;
      6: return 8;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/cram_ctrl.sv
module cram_ctrl
  import cram_pkg::*;
#(
  parameter int NUM_WINDOWS = 2,
  parameter logic [NUM_WINDOWS*BYTE_W-1:0] WINDOW_BASES = {8'h24, 8'h20}
) (
  input  logic [BYTE_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  output cramStrobes_t      stb
);
  logic [NUM_WINDOWS-1:0] winHit;

  genvar w;
  generate
    for (w = 0; w < NUM_WINDOWS; w++) begin : g_win
      localparam logic [BYTE_W-1:0] BASE = WINDOW_BASES[w*BYTE_W +: BYTE_W];
      assign winHit[w] = (ioAddr[BYTE_W-1:1] == BASE[BYTE_W-1:1]);
    end
  endgenerate

  logic anyHit;
  logic isAdrPort;
  assign anyHit    = |winHit;
  assign isAdrPort = ioAddr[0];

  always_comb begin
    stb.ctlWr = anyHit && !isAdrPort && ioWrEn;
    stb.adrWr = anyHit &&  isAdrPort && ioWrEn;
    stb.ctlRd = anyHit && !isAdrPort && ioRdEn;
    stb.adrRd = anyHit &&  isAdrPort && ioRdEn;
  end
endmodule

// File: rtl/cram_datapath.sv
module cram_datapath
  import cram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cramStrobes_t      stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] ctlLatchO,
  output logic [BYTE_W-1:0] adrLatchO,
  output logic              cellBitO,
  output logic [DEPTH-1:0]  cellsO
);
  logic [BYTE_W-1:0] ctlLatch;
  logic [BYTE_W-1:0] adrLatch;
  logic [DEPTH-1:0]  cells;
  logic [ADDR_W-1:0] adrPart;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] commitAddr;

  // scatter the address latch into the cell address
  genvar i;
  generate
    for (i = 0; i < BYTE_W; i++) begin : g_scatter
      assign adrPart[adrBitPos(i)] = adrLatch[i];
    end
  endgenerate
  assign adrPart[2] = 1'b0;
  assign adrPart[3] = 1'b0;

  always_comb begin
    curAddr       = adrPart;
    curAddr[2]    = ctlLatch[A2_BIT];
    curAddr[3]    = ctlLatch[A3_BIT];
    commitAddr    = adrPart;
    commitAddr[2] = wrData[A2_BIT];
    commitAddr[3] = wrData[A3_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlLatch <= '0;
      adrLatch <= '0;
    end else begin
      if (stb.ctlWr) ctlLatch <= wrData;
      if (stb.adrWr) adrLatch <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cells <= '0;
    end else if (stb.ctlWr && wrData[SEL_BIT]) begin
      cells[commitAddr] <= wrData[DIN_BIT];
    end
  end

  logic cellBit;
  assign cellBit = cells[curAddr];

  always_comb begin
    rdData = '0;
    if (stb.ctlRd) begin
      rdData = ctlLatch;
      if (!ctlLatch[SEL_BIT]) rdData[DOUT_BIT] = cellBit;
    end else if (stb.adrRd) begin
      rdData = adrLatch;
    end
  end

  assign ctlLatchO = ctlLatch;
  assign adrLatchO = adrLatch;
  assign cellBitO  = cellBit;
  assign cellsO    = cells;
endmodule

// File: rtl/bitserial_cart_ram.sv
module bitserial_cart_ram
  import cram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioAddr,
  input  logic       ioWrEn,
  input  logic       ioRdEn,
  input  logic [7:0] ioWrData,
  output logic [7:0] ioRdData
);
  cramStrobes_t      stb;
  logic [BYTE_W-1:0] ctlLatch;
  logic [BYTE_W-1:0] adrLatch;
  logic              cellBit;
  logic [DEPTH-1:0]  cells;

  cram_ctrl #(
    .NUM_WINDOWS (2),
    .WINDOW_BASES({8'h24, 8'h20})
  ) i_ctrl (
    .ioAddr(ioAddr),
    .ioWrEn(ioWrEn),
    .ioRdEn(ioRdEn),
    .stb   (stb)
  );

  cram_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (ioWrData),
    .rdData   (ioRdData),
    .ctlLatchO(ctlLatch),
    .adrLatchO(adrLatch),
    .cellBitO (cellBit),
    .cellsO   (cells)
  );
endmodule

// File: rtl/cram_checker.sv
module cram_checker
  import cram_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        ioAddr,
  input logic              ioWrEn,
  input logic              ioRdEn,
  input logic [7:0]        ioWrData,
  input logic [7:0]        ioRdData,
  input logic [BYTE_W-1:0] ctlLatch,
  input logic [BYTE_W-1:0] adrLatch,
  input logic              cellBit,
  input logic [DEPTH-1:0]  cells
);
  logic isCtl, isAdr;
  assign isCtl = (ioAddr == 8'h20) || (ioAddr == 8'h24);
  assign isAdr = (ioAddr == 8'h21) || (ioAddr == 8'h25);

  p_ctl_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && isCtl) |=> (ctlLatch == $past(ioWrData)));

  p_adr_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && isAdr) |=> (adrLatch == $past(ioWrData)));

  p_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && isCtl && ioWrData[0]) |=> (cellBit == $past(ioWrData[3])));

  p_read_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && isCtl && !ctlLatch[0]) |-> (ioRdData == {cellBit, ctlLatch[6:0]}));

  p_write_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdEn && isCtl && ctlLatch[0]) |-> (ioRdData == ctlLatch));

  p_adr_no_ram_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && isAdr) |=> (cells == $past(cells)));

  p_unmapped_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!(ioRdEn && (isCtl || isAdr))) |-> (ioRdData == 8'h00));

  p_sel0_no_ram_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && isCtl && !ioWrData[0]) |=> (cells == $past(cells)));
endmodule

bind bitserial_cart_ram cram_checker i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ioAddr  (ioAddr),
  .ioWrEn  (ioWrEn),
  .ioRdEn  (ioRdEn),
  .ioWrData(ioWrData),
  .ioRdData(ioRdData),
  .ctlLatch(ctlLatch),
  .adrLatch(adrLatch),
  .cellBit (cellBit),
  .cells   (cells)
);

// File: tb/test_bitserial_cart_ram.sv
`timescale 1ns/1ps
module test_bitserial_cart_ram;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ioAddr = 8'h00;
  logic       ioWrEn = 1'b0;
  logic       ioRdEn = 1'b0;
  logic [7:0] ioWrData = 8'h00;
  logic [7:0] ioRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] mCtl = 8'h00;
  logic [7:0] mAdr = 8'h00;
  bit         mMem [1024];

  always #2.5 clk = ~clk;

  bitserial_cart_ram i_bitserial_cart_ram (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .ioRdEn(ioRdEn), .ioWrData(ioWrData), .ioRdData(ioRdData)
  );

  function automatic int cellIndex(input logic [7:0] c, input logic [7:0] a);
    int r;
    r = 0;
    r += a[0] * 1;
    r += a[4] * 2;
    r += c[2] * 4;
    r += c[1] * 8;
    r += a[1] * 16;
    r += a[2] * 32;
    r += a[3] * 64;
    r += a[5] * 128;
    r += a[6] * 256;
    r += a[7] * 512;
    return r;
  endfunction

  function automatic logic [7:0] expectRead(input logic [7:0] a, input bit rd);
    logic [7:0] v;
    v = 8'h00;
    if (rd && (a == 8'h20 || a == 8'h24)) begin
      v = mCtl;
      if (mCtl[0] == 1'b0) v[7] = mMem[cellIndex(mCtl, mAdr)];
    end else if (rd && (a == 8'h21 || a == 8'h25)) begin
      v = mAdr;
    end
    return v;
  endfunction

  // one bus cycle: drive at negedge, compare, then advance the model at posedge
  task automatic step(input logic [7:0] a, input bit wr, input bit rd,
                      input logic [7:0] d, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    ioAddr = a; ioWrEn = wr; ioRdEn = rd; ioWrData = d;
    #1;
    exp = expectRead(a, rd);
    checks++;
    if (ioRdData !== exp) begin
      errors++;
      $display("FAIL %s: addr=%02h rd=%0d wr=%0d actual=%02h expected=%02h",
               tag, a, rd, wr, ioRdData, exp);
    end
    @(posedge clk);
    if (wr) begin
      if (a == 8'h20 || a == 8'h24) begin
        if (d[0]) mMem[cellIndex(d, mAdr)] = d[3];
        mCtl = d;
      end else if (a == 8'h21 || a == 8'h25) begin
        mAdr = d;
      end
    end
  endtask

  task automatic storeBit(input logic [7:0] adr, input logic [1:0] hi, input bit v,
                          input string tag);
    step(8'h21, 1, 0, adr, tag);
    step(8'h20, 1, 0, {4'h0, v, hi[0], hi[1], 1'b1}, tag);
  endtask

  task automatic readBit(input logic [7:0] adr, input logic [1:0] hi, input string tag);
    step(8'h25, 1, 0, adr, tag);
    step(8'h24, 1, 0, {4'h5, 1'b0, hi[0], hi[1], 1'b0}, tag);
    step(8'h20, 0, 1, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R8: reset state of latches and cells
    step(8'h20, 0, 1, 8'h00, "R8");
    step(8'h21, 0, 1, 8'h00, "R8");
    for (int k = 0; k < 8; k++) readBit(8'(k * 37), 2'(k), "R8");

    // R7: unmapped addresses change nothing and read as zero
    step(8'h22, 1, 1, 8'hFF, "R7");
    step(8'h23, 1, 1, 8'hFF, "R7");
    step(8'h30, 1, 1, 8'hFF, "R7");
    step(8'h20, 0, 0, 8'h00, "R7");
    step(8'h25, 0, 1, 8'h00, "R7");
    step(8'h24, 0, 1, 8'h00, "R7");

    // R1, R2: latches in both windows
    step(8'h21, 1, 0, 8'hA5, "R2");
    step(8'h25, 0, 1, 8'h00, "R2");
    step(8'h24, 1, 0, 8'h6E, "R1");
    step(8'h20, 0, 1, 8'h00, "R1");

    // R3, R4: walk a one through every cell address bit
    for (int b = 0; b < 8; b++) storeBit(8'(1 << b), 2'b00, 1'b1, "R3");
    storeBit(8'h00, 2'b01, 1'b1, "R3");
    storeBit(8'h00, 2'b10, 1'b1, "R3");
    for (int b = 0; b < 8; b++) readBit(8'(1 << b), 2'b00, "R4");
    readBit(8'h00, 2'b01, "R4");
    readBit(8'h00, 2'b10, "R4");
    readBit(8'h00, 2'b00, "R4");
    readBit(8'hFF, 2'b11, "R4");

    // R5: write mode read returns the latch
    step(8'h20, 1, 0, 8'hF9, "R5");
    step(8'h24, 0, 1, 8'h00, "R5");

    // R9: read together with write shows old values
    step(8'h21, 1, 0, 8'h3C, "R9");
    step(8'h20, 1, 0, 8'h08, "R9");
    step(8'h20, 1, 1, 8'h0C, "R9");
    step(8'h21, 1, 1, 8'hC3, "R9");
    step(8'h21, 0, 1, 8'h00, "R9");

    // R10: select 0 with data 1 does not store
    readBit(8'h5A, 2'b11, "R10");
    step(8'h20, 1, 0, 8'h0E, "R10");
    step(8'h20, 0, 1, 8'h00, "R10");

    // R6: address-port writes do not store
    storeBit(8'h11, 2'b00, 1'b0, "R6");
    step(8'h21, 1, 0, 8'hFF, "R6");
    step(8'h21, 1, 0, 8'h11, "R6");
    step(8'h20, 1, 0, 8'h00, "R6");
    step(8'h20, 0, 1, 8'h00, "R6");

    // mixed traffic compared every cycle
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] a;
      logic [7:0] d;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1: a = 8'h20;
        2, 3: a = 8'h24;
        4:    a = 8'h21;
        5:    a = 8'h25;
        6:    a = 8'h23;
        default: a = (pick == 7) ? 8'h20 : 8'h24;
      endcase
      d = 8'($urandom);
      if (n % 97 == 0) d[7:0] = 8'($urandom_range(0, 3));
      step(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d, "RND");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule